// File: doc/BRIEF.md
# Prioritized Multi-Port Data Register File

This block is the operand store of a compute datapath. It holds two banks of sixteen 40-bit registers, a primary bank and an alternate bank. At any time one bank is active, and every port addresses that bank. Two operand read ports feed the arithmetic units. Two memory-side read paths and four write sources connect the file to the rest of the datapath. The four write sources are the data-memory/general register move path, the program-memory path, the primary ALU and the secondary ALU.

Each write source and each memory-side read path has a width flag that selects between 40-bit and 32-bit transfers. A 32-bit value always occupies the top 32 bits of a register. Reads are combinational from the stored state, and writes land on the clock edge, so a register that is read and written in the same cycle gives its old contents to the reader. When several enabled sources write the same register in one cycle, a fixed source priority picks the single write that takes effect.

Top module: `prio_regfile`

## Requirements
- R1: After reset, every register in both banks reads as zero.
- R2: A 40-bit write (narrow flag 0) stores all 40 data bits. The value is readable on both operand ports and on a memory-side read path in 40-bit mode from the cycle after the write edge.
- R3: A 32-bit write (narrow flag 1) stores write-data bits [39:8] into register bits [39:8] and clears register bits [7:0], whatever the previous contents and the data's low byte.
- R4: A memory-side read with narrow flag 1 returns register bits [39:8] in place with bits [7:0] forced to zero. With narrow flag 0 it returns all 40 bits.
- R5: When a register is read and written in the same cycle, the read returns the pre-write value during that cycle. The new value appears after the edge.
- R6: Enabled writes that target the same register in one cycle resolve by source priority, from highest to lowest: data-memory, program-memory, primary ALU, secondary ALU. Only the winner's data is stored.
- R7: Enabled writes to different registers in the same cycle all take effect.
- R8: A write with its enable low changes no register and does not block a lower-priority write to the same address.
- R9: bank_sel is sampled on the clock edge (0 selects primary, 1 selects alternate). From the cycle after that edge, all ports address the selected bank, and each bank keeps its own contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 1 | Requested bank (0 primary, 1 alternate), registered |
| opa_addr | input | 4 | Operand port A register index |
| opa_data | output | 40 | Operand port A data |
| opb_addr | input | 4 | Operand port B register index |
| opb_data | output | 40 | Operand port B data |
| dm_rd_addr | input | 4 | Data-memory read path index |
| dm_rd_narrow | input | 1 | Data-memory read 32-bit mode |
| dm_rd_data | output | 40 | Data-memory read data |
| pm_rd_addr | input | 4 | Program-memory read path index |
| pm_rd_narrow | input | 1 | Program-memory read 32-bit mode |
| pm_rd_data | output | 40 | Program-memory read data |
| dm_wr_en | input | 1 | Data-memory write enable |
| dm_wr_addr | input | 4 | Data-memory write index |
| dm_wr_narrow | input | 1 | Data-memory write 32-bit mode |
| dm_wr_data | input | 40 | Data-memory write data |
| pm_wr_en | input | 1 | Program-memory write enable |
| pm_wr_addr | input | 4 | Program-memory write index |
| pm_wr_narrow | input | 1 | Program-memory write 32-bit mode |
| pm_wr_data | input | 40 | Program-memory write data |
| alux_wr_en | input | 1 | Primary ALU write enable |
| alux_wr_addr | input | 4 | Primary ALU write index |
| alux_wr_narrow | input | 1 | Primary ALU write 32-bit mode |
| alux_wr_data | input | 40 | Primary ALU write data |
| aluy_wr_en | input | 1 | Secondary ALU write enable |
| aluy_wr_addr | input | 4 | Secondary ALU write index |
| aluy_wr_narrow | input | 1 | Secondary ALU write 32-bit mode |
| aluy_wr_data | input | 40 | Secondary ALU write data |

## Verification
Two kinds of event can share a cycle: a read and a write of the same register, and several writes aimed at one register. The bench sets up the first case by holding an operand address on a register while a source writes it. It samples the port before the edge, expecting the old value, and again after the edge, expecting the new value. For the second case it enables subsets of the four sources on one address with distinct data and expects the stored word to be the data of the highest-priority enabled source. The cases with a source disabled, and with every source aimed at a different address, are judged in the same way.

// File: rtl/rf_pkg.sv
package rf_pkg;
   // Write sources, listed from highest to lowest priority.
   typedef enum int unsigned {
      SRC_DM   = 0,
      SRC_PM   = 1,
      SRC_ALUX = 2,
      SRC_ALUY = 3
   } rf_src_e;

   localparam int unsigned NUM_SRC  = 4;
   localparam int unsigned NUM_BANK = 2;
endpackage

// File: rtl/rf_write_arbiter.sv
module rf_write_arbiter #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned NSRC   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   req_en,
   input  logic [ADDR_W-1:0] req_addr [NSRC],
   output logic [NSRC-1:0]   grant
);
   if (NSRC < 2) begin : g_chk_nsrc
      $error("rf_write_arbiter: NSRC must be at least 2");
   end

   // Index 0 is the most important source. A source loses only to an
   // enabled, more important source that aims at the same register.
   for (genvar s = 0; s < NSRC; s++) begin : g_src
      if (s == 0) begin : g_top
         assign grant[s] = req_en[s];
      end else begin : g_lower
         logic [s-1:0] beaten;
         for (genvar h = 0; h < s; h++) begin : g_higher
            assign beaten[h] = req_en[h] && (req_addr[h] == req_addr[s]);
         end
         assign grant[s] = req_en[s] && (beaten == '0);
      end
   end

   // R6: the top-priority source is never refused
   p_top_source_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_en[0] |-> grant[0]);
endmodule

// File: rtl/rf_bank_store.sv
module rf_bank_store #(
   parameter int unsigned DATA_W = 40,
   parameter int unsigned NREG   = 16,
   parameter int unsigned NBANK  = 2,
   parameter int unsigned NSRC   = 4,
   localparam int unsigned ADDR_W = $clog2(NREG),
   localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] bank,
   input  logic [NSRC-1:0]   grant,
   input  logic [ADDR_W-1:0] wr_addr [NSRC],
   input  logic [DATA_W-1:0] wr_word [NSRC],
   output logic [DATA_W-1:0] view    [NREG]
);
   if (NREG < 2 || (1 << ADDR_W) != NREG) begin : g_chk_nreg
      $error("rf_bank_store: NREG must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] cells [NBANK][NREG];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      for (genvar r = 0; r < NREG; r++) begin : g_reg
         logic [NSRC-1:0] hit;
         for (genvar s = 0; s < NSRC; s++) begin : g_hit
            assign hit[s] = grant[s] && (wr_addr[s] == ADDR_W'(r))
                            && (bank == BANK_W'(b));
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cells[b][r] <= '0;
            end else begin
               for (int s = 0; s < NSRC; s++) begin
                  if (hit[s]) cells[b][r] <= wr_word[s];
               end
            end
         end

         // R6: arbitration leaves at most one writer per register
         p_single_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hit));
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_view
      assign view[r] = cells[bank][r];
   end
endmodule

// File: rtl/rf_read_fmt.sv
module rf_read_fmt #(
   parameter int unsigned DATA_W   = 40,
   parameter int unsigned NARROW_W = 32,
   localparam int unsigned LOW_W   = DATA_W - NARROW_W
) (
   input  logic [DATA_W-1:0] word,
   input  logic              narrow,
   output logic [DATA_W-1:0] data
);
   if (NARROW_W == 0 || NARROW_W >= DATA_W) begin : g_chk_w
      $error("rf_read_fmt: NARROW_W must lie between 1 and DATA_W-1");
   end

   always_comb begin
      data = word;
      if (narrow) data[LOW_W-1:0] = '0;
   end
endmodule

// File: rtl/prio_regfile.sv
module prio_regfile #(
   parameter int unsigned DATA_W   = 40,
   parameter int unsigned NARROW_W = 32,
   parameter int unsigned NREG     = 16,
   localparam int unsigned ADDR_W  = $clog2(NREG),
   localparam int unsigned LOW_W   = DATA_W - NARROW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_sel,
   input  logic [ADDR_W-1:0] opa_addr,
   output logic [DATA_W-1:0] opa_data,
   input  logic [ADDR_W-1:0] opb_addr,
   output logic [DATA_W-1:0] opb_data,
   input  logic [ADDR_W-1:0] dm_rd_addr,
   input  logic              dm_rd_narrow,
   output logic [DATA_W-1:0] dm_rd_data,
   input  logic [ADDR_W-1:0] pm_rd_addr,
   input  logic              pm_rd_narrow,
   output logic [DATA_W-1:0] pm_rd_data,
   input  logic              dm_wr_en,
   input  logic [ADDR_W-1:0] dm_wr_addr,
   input  logic              dm_wr_narrow,
   input  logic [DATA_W-1:0] dm_wr_data,
   input  logic              pm_wr_en,
   input  logic [ADDR_W-1:0] pm_wr_addr,
   input  logic              pm_wr_narrow,
   input  logic [DATA_W-1:0] pm_wr_data,
   input  logic              alux_wr_en,
   input  logic [ADDR_W-1:0] alux_wr_addr,
   input  logic              alux_wr_narrow,
   input  logic [DATA_W-1:0] alux_wr_data,
   input  logic              aluy_wr_en,
   input  logic [ADDR_W-1:0] aluy_wr_addr,
   input  logic              aluy_wr_narrow,
   input  logic [DATA_W-1:0] aluy_wr_data
);
   import rf_pkg::*;

   if (NARROW_W == 0 || NARROW_W >= DATA_W) begin : g_chk_w
      $error("prio_regfile: NARROW_W must lie between 1 and DATA_W-1");
   end

   localparam int unsigned BANK_W = 1;

   // Registered bank choice: a new bank is used from the next cycle on.
   logic [BANK_W-1:0] bank_q;
   always_ff @(posedge clk) begin
      if (!rst_n) bank_q <= '0;
      else        bank_q <= bank_sel;
   end

   // Gather the sources in priority order.
   logic [NUM_SRC-1:0] src_en;
   logic [NUM_SRC-1:0] src_narrow;
   logic [ADDR_W-1:0]  src_addr [NUM_SRC];
   logic [DATA_W-1:0]  src_data [NUM_SRC];
   logic [DATA_W-1:0]  src_word [NUM_SRC];
   logic [NUM_SRC-1:0] grant;

   assign src_en     = {aluy_wr_en, alux_wr_en, pm_wr_en, dm_wr_en};
   assign src_narrow = {aluy_wr_narrow, alux_wr_narrow, pm_wr_narrow, dm_wr_narrow};
   assign src_addr[SRC_DM]   = dm_wr_addr;
   assign src_addr[SRC_PM]   = pm_wr_addr;
   assign src_addr[SRC_ALUX] = alux_wr_addr;
   assign src_addr[SRC_ALUY] = aluy_wr_addr;
   assign src_data[SRC_DM]   = dm_wr_data;
   assign src_data[SRC_PM]   = pm_wr_data;
   assign src_data[SRC_ALUX] = alux_wr_data;
   assign src_data[SRC_ALUY] = aluy_wr_data;

   // A 32-bit write keeps the upper field and clears the low byte.
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_wfmt
      assign src_word[s] = src_narrow[s]
         ? {src_data[s][DATA_W-1 -: NARROW_W], {LOW_W{1'b0}}}
         : src_data[s];
   end

   rf_write_arbiter #(.ADDR_W(ADDR_W), .NSRC(NUM_SRC)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_en   (src_en),
      .req_addr (src_addr),
      .grant    (grant)
   );

   logic [DATA_W-1:0] view [NREG];

   rf_bank_store #(
      .DATA_W (DATA_W),
      .NREG   (NREG),
      .NBANK  (NUM_BANK),
      .NSRC   (NUM_SRC)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .bank    (bank_q),
      .grant   (grant),
      .wr_addr (src_addr),
      .wr_word (src_word),
      .view    (view)
   );

   assign opa_data = view[opa_addr];
   assign opb_data = view[opb_addr];

   rf_read_fmt #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_dm_rd (
      .word   (view[dm_rd_addr]),
      .narrow (dm_rd_narrow),
      .data   (dm_rd_data)
   );

   rf_read_fmt #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_pm_rd (
      .word   (view[pm_rd_addr]),
      .narrow (pm_rd_narrow),
      .data   (pm_rd_data)
   );

   // R2: a full-width data-memory write is visible on operand port A next cycle
   p_wide_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(dm_wr_en) && !$past(dm_wr_narrow)
       && opa_addr == $past(dm_wr_addr) && bank_q == $past(bank_q))
      |-> opa_data == $past(dm_wr_data));

   // R3: a 32-bit data-memory write leaves a cleared low byte
   p_narrow_clears_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(dm_wr_en) && $past(dm_wr_narrow)
       && opa_addr == $past(dm_wr_addr) && bank_q == $past(bank_q))
      |-> (opa_data[LOW_W-1:0] == '0
           && opa_data[DATA_W-1 -: NARROW_W] == $past(dm_wr_data[DATA_W-1 -: NARROW_W])));
endmodule

// File: tb/sim_prio_regfile.sv
module sim_prio_regfile;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bank_sel;
   logic [3:0]  opa_addr, opb_addr, dm_rd_addr, pm_rd_addr;
   logic        dm_rd_narrow, pm_rd_narrow;
   logic [39:0] opa_data, opb_data, dm_rd_data, pm_rd_data;
   logic        dm_wr_en, pm_wr_en, alux_wr_en, aluy_wr_en;
   logic [3:0]  dm_wr_addr, pm_wr_addr, alux_wr_addr, aluy_wr_addr;
   logic        dm_wr_narrow, pm_wr_narrow, alux_wr_narrow, aluy_wr_narrow;
   logic [39:0] dm_wr_data, pm_wr_data, alux_wr_data, aluy_wr_data;

   int n_run = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   prio_regfile u0 (.*);

   task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      dm_wr_en = 0; pm_wr_en = 0; alux_wr_en = 0; aluy_wr_en = 0;
      dm_wr_narrow = 0; pm_wr_narrow = 0; alux_wr_narrow = 0; aluy_wr_narrow = 0;
   endtask

   // Advance one edge, then let the combinational reads settle.
   task automatic step();
      @(posedge clk);
      #2;
      idle();
      #1;
   endtask

   task automatic put_wide(input logic [3:0] a, input logic [39:0] d);
      dm_wr_en = 1; dm_wr_addr = a; dm_wr_narrow = 0; dm_wr_data = d;
      step();
   endtask

   task automatic t_reset();
      for (int i = 0; i < 16; i++) begin
         opa_addr = 4'(i); #1;
         check("R1 primary bank cleared", opa_data, 40'h0);
      end
   endtask

   task automatic t_wide();
      put_wide(4'd3, 40'hA5_1234_5678);
      opa_addr = 3; opb_addr = 3; dm_rd_addr = 3; dm_rd_narrow = 0;
      pm_rd_addr = 3; pm_rd_narrow = 1; #1;
      check("R2 operand A", opa_data, 40'hA5_1234_5678);
      check("R2 operand B", opb_data, 40'hA5_1234_5678);
      check("R2 wide memory read", dm_rd_data, 40'hA5_1234_5678);
      check("R4 narrow memory read", pm_rd_data, 40'hA5_1234_5600);
      pm_rd_narrow = 0; #1;
      check("R4 wide program read", pm_rd_data, 40'hA5_1234_5678);
   endtask

   task automatic t_narrow();
      alux_wr_en = 1; alux_wr_addr = 5; alux_wr_data = 40'hFF_FFFF_FFFF;
      step();
      pm_wr_en = 1; pm_wr_addr = 5; pm_wr_narrow = 1; pm_wr_data = 40'h12_3456_7899;
      step();
      opa_addr = 5; dm_rd_addr = 5; dm_rd_narrow = 0; #1;
      check("R3 narrow write clears low byte", opa_data, 40'h12_3456_7800);
      check("R3 narrow write wide readback", dm_rd_data, 40'h12_3456_7800);
   endtask

   task automatic t_rbw();
      put_wide(4'd7, 40'h00_1111_2222);
      opa_addr = 7;
      alux_wr_en = 1; alux_wr_addr = 7; alux_wr_data = 40'h33_4444_5555;
      #1;
      check("R5 old value during write cycle", opa_data, 40'h00_1111_2222);
      step();
      check("R5 new value after edge", opa_data, 40'h33_4444_5555);
   endtask

   task automatic t_prio();
      opa_addr = 9;
      dm_wr_en = 1; dm_wr_addr = 9; dm_wr_data = 40'h01;
      pm_wr_en = 1; pm_wr_addr = 9; pm_wr_data = 40'h02;
      alux_wr_en = 1; alux_wr_addr = 9; alux_wr_data = 40'h03;
      aluy_wr_en = 1; aluy_wr_addr = 9; aluy_wr_data = 40'h04;
      step();
      check("R6 data-memory beats all", opa_data, 40'h01);
      pm_wr_en = 1; pm_wr_addr = 9; pm_wr_data = 40'h12;
      alux_wr_en = 1; alux_wr_addr = 9; alux_wr_data = 40'h13;
      aluy_wr_en = 1; aluy_wr_addr = 9; aluy_wr_data = 40'h14;
      step();
      check("R6 program-memory beats ALUs", opa_data, 40'h12);
      alux_wr_en = 1; alux_wr_addr = 9; alux_wr_data = 40'h23;
      aluy_wr_en = 1; aluy_wr_addr = 9; aluy_wr_data = 40'h24;
      step();
      check("R6 primary ALU beats secondary", opa_data, 40'h23);
      aluy_wr_en = 1; aluy_wr_addr = 9; aluy_wr_data = 40'h34;
      step();
      check("R6 secondary ALU alone", opa_data, 40'h34);
   endtask

   task automatic t_disabled();
      put_wide(4'd10, 40'h77_0000_0001);
      dm_wr_en = 0; dm_wr_addr = 9; dm_wr_data = 40'hEE;
      pm_wr_en = 1; pm_wr_addr = 9; pm_wr_data = 40'h55;
      aluy_wr_en = 0; aluy_wr_addr = 10; aluy_wr_data = 40'hBAD;
      #1;
      dm_wr_en = 0; aluy_wr_en = 0;
      step();
      opa_addr = 9; opb_addr = 10; #1;
      check("R8 disabled source does not block", opa_data, 40'h55);
      check("R8 disabled write leaves register", opb_data, 40'h77_0000_0001);
   endtask

   task automatic t_parallel();
      dm_wr_en = 1; dm_wr_addr = 1; dm_wr_data = 40'hA1;
      pm_wr_en = 1; pm_wr_addr = 2; pm_wr_data = 40'hB2;
      alux_wr_en = 1; alux_wr_addr = 4; alux_wr_data = 40'hC4;
      aluy_wr_en = 1; aluy_wr_addr = 6; aluy_wr_data = 40'hD6;
      step();
      opa_addr = 1; opb_addr = 2; #1;
      check("R7 data-memory lane", opa_data, 40'hA1);
      check("R7 program-memory lane", opb_data, 40'hB2);
      opa_addr = 4; opb_addr = 6; #1;
      check("R7 primary ALU lane", opa_data, 40'hC4);
      check("R7 secondary ALU lane", opb_data, 40'hD6);
   endtask

   task automatic t_bank();
      opa_addr = 3;
      bank_sel = 1; #1;
      check("R9 bank unchanged before edge", opa_data, 40'hA5_1234_5678);
      step();
      check("R9 alternate bank starts cleared", opa_data, 40'h0);
      put_wide(4'd3, 40'h99_8888_7777);
      check("R9 alternate write", opa_data, 40'h99_8888_7777);
      bank_sel = 0;
      step();
      check("R9 primary bank intact", opa_data, 40'hA5_1234_5678);
      bank_sel = 1;
      step();
      check("R9 alternate bank kept", opa_data, 40'h99_8888_7777);
      bank_sel = 0;
      step();
   endtask

   initial begin
      #200000;
      n_run++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      rst_n = 0; bank_sel = 0; idle();
      opa_addr = 0; opb_addr = 0; dm_rd_addr = 0; pm_rd_addr = 0;
      dm_rd_narrow = 0; pm_rd_narrow = 0;
      dm_wr_addr = 0; pm_wr_addr = 0; alux_wr_addr = 0; aluy_wr_addr = 0;
      dm_wr_data = 0; pm_wr_data = 0; alux_wr_data = 0; aluy_wr_data = 0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      #1;
      t_reset();
      t_wide();
      t_narrow();
      t_rbw();
      t_prio();
      t_disabled();
      t_parallel();
      t_bank();
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule